// File: doc/BRIEF.md
# Wait-State Sequencer with Reset Stabilization

This block stands between a small processor core and its clock tree. When the core requests a wait-for-interrupt, the sequencer stops the core clock. The peripheral clock keeps running, and the block holds a force-clear on the two interrupt-mask bits so that every interrupt source can wake the core. The sequencer reports its operating mode on a 3-bit status output.

There are two ways to wake the core. A pending interrupt re-enables the core clock on the next edge and pulses a wake indication, which tells the core to branch straight to the service entry. A reset request instead enters a stabilization phase of `STAB_CYCLES` (default 512) oscillator cycles with the core clock held off. At the end of that phase the block pulses a reset-vector fetch indication.

Clock enables reach the gated clocks through a latch that is transparent only while the oscillator clock is low, so each gated clock can change only on a falling edge. Every pin is plain control or status. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `wseq_ctrl`

## Requirements
- R1: After `rst_ni` is released, `mode_o` is 3'b000 (low-power run), `cpu_clk_en_o` and `per_clk_en_o` are 1, and `mask_clr_o`, `irq_wake_o` and `vec_fetch_o` are 0.
- R2: In run, `wfi_req_i` high with `irq_pend_i` low causes wait from the next edge: `mode_o` = 3'b001, `cpu_clk_en_o` = 0, `per_clk_en_o` = 1.
- R3: `mask_clr_o` is 1 in every wait cycle and 0 in run and during stabilization.
- R4: Wait persists with no wake pulse for as long as neither `irq_pend_i` nor `rst_req_i` is high, whatever `wfi_req_i` does.
- R5: In wait, `irq_pend_i` high returns the block to run on the next edge (`mode_o` = 3'b000, `cpu_clk_en_o` = 1) and raises `irq_wake_o` for exactly one cycle.
- R6: `rst_req_i` high in any state enters stabilization on the next edge: `cpu_clk_en_o` = 0, `mode_o` = 3'b001, `mask_clr_o` = 0. After exactly `STAB_CYCLES` stabilization cycles, the block returns to run with `vec_fetch_o` high for one cycle.
- R7: When `rst_req_i` and `irq_pend_i` are high in the same cycle, the stabilization path is taken and `irq_wake_o` stays 0.
- R8: In run, `wfi_req_i` high while `irq_pend_i` is high does not enter wait. The block stays in run and pulses `irq_wake_o` on the next cycle, so the wake-up is not lost.
- R9: `cpu_gclk_o` shows no rising edge while the block is in wait, and it resumes on the edge after an interrupt wake. `per_gclk_o` keeps running during wait.
- R10: In run, `irq_pend_i` without `wfi_req_i` has no effect: no wake pulse and no mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset of the sequencer |
| wfi_req_i | input | 1 | Wait-for-interrupt request from the core |
| irq_pend_i | input | 1 | An interrupt is pending |
| rst_req_i | input | 1 | Reset event; starts the stabilization delay |
| cpu_clk_en_o | output | 1 | Core clock enable before the gating latch |
| per_clk_en_o | output | 1 | Peripheral clock enable before the gating latch |
| cpu_gclk_o | output | 1 | Gated core clock |
| per_gclk_o | output | 1 | Gated peripheral clock |
| mask_clr_o | output | 1 | Forces both interrupt-mask bits to 0 |
| irq_wake_o | output | 1 | One-cycle pulse: resume at interrupt service entry |
| vec_fetch_o | output | 1 | One-cycle pulse: fetch the reset vector |
| mode_o | output | 3 | Mode status: 000 LP run, 001 LP wait, 010 FP run, 011 FP wait, 100 halt |

## Verification
The hardest case to reach from the ports is the exact end of the stabilization window. The bench must show that the vector-fetch pulse lands on the 512th cycle, neither the 511th nor the 513th. To do this it raises the reset request for a single cycle and then steps the clock one edge at a time, checking on every cycle that the core clock stays off and that no fetch pulse appears early.

Collisions are the other hard area. The bench drives a reset together with an interrupt, and a wait request together with an already pending interrupt, on the same cycle. This exercises the priority order and the immediate-return path. Rising edges of the gated core clock are counted over a wait interval to show that the clock is silent.

// File: rtl/wseq_pkg.sv
package wseq_pkg;
  typedef enum logic [2:0] {
    MODE_LP_RUN  = 3'b000,
    MODE_LP_WAIT = 3'b001,
    MODE_FP_RUN  = 3'b010,
    MODE_FP_WAIT = 3'b011,
    MODE_HALT    = 3'b100
  } mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_WAIT = 2'd1,
    ST_STAB = 2'd2
  } seq_st_e;
endpackage

// File: rtl/wseq_clk_gate.sv
module wseq_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // Transparent only in the low phase: the enable can change the
  // gated clock only after a falling edge of the source.
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/wseq_stab_cnt.sv
module wseq_stab_cnt #(
  parameter int STAB_CYCLES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [W-1:0] LAST = W'(STAB_CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && !clear_i && (cnt_q == LAST);

  assert_cnt_cleared_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/wseq_fsm.sv
module wseq_fsm
  import wseq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wfi_req_i,
  input  logic    irq_pend_i,
  input  logic    rst_req_i,
  input  logic    stab_done_i,
  output seq_st_e st_o,
  output logic    irq_wake_o,
  output logic    vec_fetch_o
);
  seq_st_e st_q, st_d;
  logic    wake_d, fetch_d;

  always_comb begin
    st_d    = st_q;
    wake_d  = 1'b0;
    fetch_d = 1'b0;
    if (rst_req_i) begin
      st_d = ST_STAB;                      // reset wins over any interrupt
    end else begin
      unique case (st_q)
        ST_RUN: if (wfi_req_i) begin
          if (irq_pend_i) wake_d = 1'b1;   // pending wake is not lost
          else            st_d   = ST_WAIT;
        end
        ST_WAIT: if (irq_pend_i) begin
          st_d   = ST_RUN;
          wake_d = 1'b1;
        end
        ST_STAB: if (stab_done_i) begin
          st_d    = ST_RUN;
          fetch_d = 1'b1;
        end
        default: st_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_RUN;
      irq_wake_o  <= 1'b0;
      vec_fetch_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      irq_wake_o  <= wake_d;
      vec_fetch_o <= fetch_d;
    end
  end

  assign st_o = st_q;

  assert_wake_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_wake_o && vec_fetch_o));
  assert_wait_leave_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT && !irq_pend_i && !rst_req_i) |=> (st_q == ST_WAIT && !irq_wake_o));
endmodule

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import wseq_pkg::*;
#(
  parameter int STAB_CYCLES = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wfi_req_i,
  input  logic       irq_pend_i,
  input  logic       rst_req_i,
  output logic       cpu_clk_en_o,
  output logic       per_clk_en_o,
  output logic       cpu_gclk_o,
  output logic       per_gclk_o,
  output logic       mask_clr_o,
  output logic       irq_wake_o,
  output logic       vec_fetch_o,
  output logic [2:0] mode_o
);
  localparam int NUM_GATES = 2;
  localparam int LW = $clog2(STAB_CYCLES + 1) + 1;

  seq_st_e              st;
  logic                 stab_done;
  logic [NUM_GATES-1:0] gate_en, gate_clk;
  mode_e                mode;

  wseq_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wfi_req_i   (wfi_req_i),
    .irq_pend_i  (irq_pend_i),
    .rst_req_i   (rst_req_i),
    .stab_done_i (stab_done),
    .st_o        (st),
    .irq_wake_o  (irq_wake_o),
    .vec_fetch_o (vec_fetch_o)
  );

  wseq_stab_cnt #(.STAB_CYCLES(STAB_CYCLES)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (rst_req_i),
    .run_i   (st == ST_STAB),
    .done_o  (stab_done)
  );

  assign cpu_clk_en_o = (st == ST_RUN);
  assign per_clk_en_o = 1'b1;             // halt is not modelled
  assign mask_clr_o   = (st == ST_WAIT);
  assign mode         = (st == ST_RUN) ? MODE_LP_RUN : MODE_LP_WAIT;
  assign mode_o       = mode;

  assign gate_en = {per_clk_en_o, cpu_clk_en_o};

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_gate
    wseq_clk_gate u_gate (
      .clk_i  (clk_i),
      .en_i   (gate_en[g]),
      .gclk_o (gate_clk[g])
    );
  end

  assign cpu_gclk_o = gate_clk[0];
  assign per_gclk_o = gate_clk[1];

  // Window counter for the stabilization-length check.
  logic [LW-1:0] stab_len;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       stab_len <= '0;
    else if (st != ST_STAB)            stab_len <= '0;
    else if (rst_req_i)                stab_len <= '0;
    else if (stab_len != LW'(STAB_CYCLES)) stab_len <= stab_len + 1'b1;
  end

  assert_stab_length_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_fetch_o |-> (stab_len == LW'(STAB_CYCLES)));
  assert_rst_priority_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (!irq_wake_o && !cpu_clk_en_o && !mask_clr_o));
  assert_irq_wake_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_clr_o && irq_pend_i && !rst_req_i) |=> (irq_wake_o && cpu_clk_en_o));
  assert_mask_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mask_clr_o) |-> $past(wfi_req_i && !irq_pend_i && !rst_req_i));
endmodule

// File: tb/wseq_ctrl_test.sv
module wseq_ctrl_test;
  localparam int STAB = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 1'b0, irq = 1'b0, rreq = 1'b0;
  logic cpu_en, per_en, cpu_gclk, per_gclk, mask_clr, irq_wake, vec_fetch;
  logic [2:0] mode;
  int checks = 0, errors = 0;
  int cpu_edges = 0, per_edges = 0;

  always #2.5 clk = ~clk;

  wseq_ctrl #(.STAB_CYCLES(STAB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wfi_req_i(wfi), .irq_pend_i(irq),
    .rst_req_i(rreq), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .cpu_gclk_o(cpu_gclk), .per_gclk_o(per_gclk), .mask_clr_o(mask_clr),
    .irq_wake_o(irq_wake), .vec_fetch_o(vec_fetch), .mode_o(mode)
  );

  always @(posedge cpu_gclk) cpu_edges++;
  always @(posedge per_gclk) per_edges++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wfi = 0; irq = 0; rreq = 0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R1 mode", mode, 0); chk("R1 cpu_en", cpu_en, 1);
    chk("R1 per_en", per_en, 1); chk("R1 mask", mask_clr, 0);
    chk("R1 wake", irq_wake, 0); chk("R1 fetch", vec_fetch, 0);
  endtask

  task automatic t_enter_wait();
    wfi = 1; tick(); wfi = 0;
    chk("R2 mode", mode, 1); chk("R2 cpu_en", cpu_en, 0);
    chk("R2 per_en", per_en, 1); chk("R3 mask in wait", mask_clr, 1);
  endtask

  task automatic t_wait_hold();
    int c0 = cpu_edges, p0 = per_edges;
    for (int i = 0; i < 6; i++) begin
      wfi = (i % 2 == 0);
      tick();
      chk("R4 still waiting", mode, 1);
      chk("R4 no wake", irq_wake, 0);
    end
    wfi = 0;
    chk("R9 cpu clock silent", cpu_edges - c0, 0);
    chk("R9 peripheral clock runs", per_edges - p0, 6);
  endtask

  task automatic t_irq_wake();
    int c0;
    irq = 1; tick(); irq = 0;
    chk("R5 mode", mode, 0); chk("R5 cpu_en", cpu_en, 1);
    chk("R5 wake pulse", irq_wake, 1); chk("R3 mask off in run", mask_clr, 0);
    c0 = cpu_edges;
    tick();
    chk("R5 wake one cycle", irq_wake, 0);
    chk("R9 cpu clock resumes", cpu_edges - c0, 1);
  endtask

  task automatic t_rst_wake(bit with_irq);
    string tag = with_irq ? "R7" : "R6";
    rreq = 1; irq = with_irq; tick(); rreq = 0; irq = 0;
    chk({tag, " stab cpu_en"}, cpu_en, 0);
    chk({tag, " stab mode"}, mode, 1);
    chk({tag, " no irq wake"}, irq_wake, 0);
    chk("R3 mask off in stab", mask_clr, 0);
    for (int i = 1; i < STAB; i++) begin
      tick();
      if (vec_fetch !== 1'b0 || cpu_en !== 1'b0) begin
        chk({tag, " early fetch/enable"}, i, -1);
        break;
      end
    end
    tick();
    chk({tag, " fetch at 512"}, vec_fetch, 1);
    chk({tag, " run after stab"}, mode, 0);
    chk({tag, " cpu_en after stab"}, cpu_en, 1);
    tick();
    chk({tag, " fetch one cycle"}, vec_fetch, 0);
  endtask

  task automatic t_wfi_pending();
    wfi = 1; irq = 1; tick(); wfi = 0; irq = 0;
    chk("R8 stays run", mode, 0);
    chk("R8 cpu_en", cpu_en, 1);
    chk("R8 wake pulse", irq_wake, 1);
    tick();
    chk("R8 still run", mode, 0);
  endtask

  task automatic t_irq_in_run();
    irq = 1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R10 no wake", irq_wake, 0);
      chk("R10 mode run", mode, 0);
    end
    irq = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_irq_in_run();
    t_enter_wait();
    t_wait_hold();
    t_irq_wake();
    t_wfi_pending();
    t_enter_wait();
    t_rst_wake(1'b0);
    t_rst_wake(1'b1);
    t_enter_wait();
    t_irq_wake();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule